// File: doc/BRIEF.md
# Bridge Window Address Router

This block sits on an upstream request bus and steers each request to exactly one destination. A class bit splits traffic first. Memory and inter-processor requests go straight to a system-bus channel. Local I/O requests are checked against a set of bridge windows. Each bridge port owns one contiguous address window, given by a lower and an upper bound. That window spans every range assigned below that bridge, so a whole subtree, and possibly several downstream buses, looks like one block.

A local I/O request goes to the bridge port whose window contains its address. If no window claims it, the request goes to the default port by subtractive decode, one cycle after the positive decode found nothing. When the default port is switched off, the block raises an unsupported-request pulse and drops the request.

All request channels are valid/ready. The block holds one request at a time. `in_ready` is high only when no request is held. An output's valid stays high, with the address, data and write flag held steady, until that output's ready is seen high at a clock edge. The window bounds and the default-enable pin are static configuration. They must not change while a request is in flight.

Top module: `bwin_router`

## Requirements
- R1: While reset is held (active-low `rst_n`), `in_ready` is 1. While reset is held, every output valid and `ur_pulse` are 0.
- R2: A request is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the request has left by handshake or by error pulse.
- R3: A local I/O request (`in_cls` = 0) whose address lies in a valid window of port i, with both bounds inclusive, shows as `port_valid[i]`. The valid appears after the first rising edge that follows the accepting edge.
- R4: A window whose upper bound is below its lower bound never claims any address.
- R5: When several valid windows contain the address, only the port with the lowest index is given the request.
- R6: A local I/O request that no valid window contains goes to the default output (`dflt_valid`) when `dflt_en` is 1. It appears one cycle later than a positive claim would.
- R7: A local I/O request that no valid window contains, while `dflt_en` is 0, drives `ur_pulse` high for exactly one cycle, at the time the default valid would have appeared. No output valid is raised for it, and `in_ready` returns to 1 in the next cycle.
- R8: A request with `in_cls` = 1 (memory or inter-processor) goes to the system output (`sys_valid`) whatever the windows hold. It has the same latency as a positive claim.
- R9: At most one output valid, or `ur_pulse`, is high in any cycle. An output valid stays high until its ready is seen at an edge. While it waits, `out_addr`, `out_data` and `out_wr` equal the accepted request and do not change. `in_ready` returns to 1 after the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream request valid |
| in_ready | output | 1 | Upstream request ready (idle) |
| in_addr | input | ADDR_W | Request address |
| in_data | input | DATA_W | Request data |
| in_wr | input | 1 | Request write flag |
| in_cls | input | 1 | 1 = memory/inter-processor, 0 = local I/O |
| win_lo | input | NUM_PORTS*ADDR_W | Lower bounds, port i at bits i*ADDR_W upward |
| win_hi | input | NUM_PORTS*ADDR_W | Upper bounds, same packing |
| dflt_en | input | 1 | 1 = a default port is present |
| port_valid | output | NUM_PORTS | Per-bridge-port request valid |
| port_ready | input | NUM_PORTS | Per-bridge-port ready |
| dflt_valid | output | 1 | Default port request valid |
| dflt_ready | input | 1 | Default port ready |
| sys_valid | output | 1 | System-bus request valid |
| sys_ready | input | 1 | System-bus ready |
| out_addr | output | ADDR_W | Shared outgoing address |
| out_data | output | DATA_W | Shared outgoing data |
| out_wr | output | 1 | Shared outgoing write flag |
| ur_pulse | output | 1 | Unsupported-request pulse |

## Verification
Some properties are checked on every cycle. A bridge port is only ever given an address that lies inside its own valid window, and no lower-indexed window also holds that address. The default port only gets addresses that no window holds. Destinations stay mutually exclusive, a stalled output keeps its valid and payload, upstream stays blocked while a request is held, and the error pulse lasts one cycle. Other behaviour only the bench scenarios can show: the exact latency of each path, the extra cycle of subtractive decode, the inclusive bounds, the class split overriding the windows, and the return of `in_ready` after each kind of completion. The bench shows these by comparing against its own model on every clock.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_SUB,
    ST_SEND,
    ST_ERR
  } rt_state_e;

  typedef enum logic [1:0] {
    TGT_PORT,
    TGT_DFLT,
    TGT_SYS
  } rt_tgt_e;

  localparam logic CLS_SYS = 1'b1;
endpackage

// File: rtl/bwin_match.sv
module bwin_match #(
  parameter int ADDR_W    = 32,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_PORTS*ADDR_W-1:0] win_lo,
  input  logic [NUM_PORTS*ADDR_W-1:0] win_hi,
  output logic [NUM_PORTS-1:0]        hit
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_win
    logic [ADDR_W-1:0] lo_b, hi_b;
    logic              ok;
    assign lo_b   = win_lo[g*ADDR_W +: ADDR_W];
    assign hi_b   = win_hi[g*ADDR_W +: ADDR_W];
    assign ok     = (hi_b >= lo_b);
    assign hit[g] = ok && (addr >= lo_b) && (addr <= hi_b);
  end
endmodule

// File: rtl/bwin_prio.sv
module bwin_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [N-1:0] grant
);
  // lowest set bit isolated by two's complement
  assign grant = req & (~req + N'(1));
  assign any   = |req;
endmodule

// File: rtl/bwin_router.sv
module bwin_router
  import bwin_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [DATA_W-1:0]           in_data,
  input  logic                        in_wr,
  input  logic                        in_cls,
  input  logic [NUM_PORTS*ADDR_W-1:0] win_lo,
  input  logic [NUM_PORTS*ADDR_W-1:0] win_hi,
  input  logic                        dflt_en,
  output logic [NUM_PORTS-1:0]        port_valid,
  input  logic [NUM_PORTS-1:0]        port_ready,
  output logic                        dflt_valid,
  input  logic                        dflt_ready,
  output logic                        sys_valid,
  input  logic                        sys_ready,
  output logic [ADDR_W-1:0]           out_addr,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_wr,
  output logic                        ur_pulse
);
  rt_state_e            st;
  rt_tgt_e              kind;
  logic [NUM_PORTS-1:0] sel;
  logic [ADDR_W-1:0]    req_addr;
  logic [DATA_W-1:0]    req_data;
  logic                 req_wr;
  logic                 req_cls;

  logic [NUM_PORTS-1:0] hit;
  logic [NUM_PORTS-1:0] grant;
  logic                 hit_any;
  logic                 sending;
  logic                 fire;

  bwin_match #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) match_i (
    .addr   (req_addr),
    .win_lo (win_lo),
    .win_hi (win_hi),
    .hit    (hit)
  );

  bwin_prio #(.N(NUM_PORTS)) prio_i (
    .req   (hit),
    .any   (hit_any),
    .grant (grant)
  );

  assign sending    = (st == ST_SEND);
  assign port_valid = (sending && kind == TGT_PORT) ? sel : '0;
  assign dflt_valid = sending && kind == TGT_DFLT;
  assign sys_valid  = sending && kind == TGT_SYS;
  assign ur_pulse   = (st == ST_ERR);
  assign in_ready   = (st == ST_IDLE);
  assign out_addr   = req_addr;
  assign out_data   = req_data;
  assign out_wr     = req_wr;

  always_comb begin
    fire = 1'b0;
    if (sending) begin
      unique case (kind)
        TGT_PORT: fire = |(sel & port_ready);
        TGT_DFLT: fire = dflt_ready;
        default:  fire = sys_ready;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= TGT_PORT;
      sel      <= '0;
      req_addr <= '0;
      req_data <= '0;
      req_wr   <= 1'b0;
      req_cls  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          req_addr <= in_addr;
          req_data <= in_data;
          req_wr   <= in_wr;
          req_cls  <= in_cls;
          st       <= ST_DEC;
        end
        ST_DEC: begin
          if (req_cls == CLS_SYS) begin
            kind <= TGT_SYS;
            st   <= ST_SEND;
          end else if (hit_any) begin
            kind <= TGT_PORT;
            sel  <= grant;
            st   <= ST_SEND;
          end else begin
            st   <= ST_SUB;
          end
        end
        ST_SUB: begin
          if (dflt_en) begin
            kind <= TGT_DFLT;
            st   <= ST_SEND;
          end else begin
            st   <= ST_ERR;
          end
        end
        ST_SEND: if (fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bwin_router_chk.sv
module bwin_router_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic [NUM_PORTS*ADDR_W-1:0] win_lo,
  input logic [NUM_PORTS*ADDR_W-1:0] win_hi,
  input logic [NUM_PORTS-1:0]        port_valid,
  input logic [NUM_PORTS-1:0]        port_ready,
  input logic                        dflt_valid,
  input logic                        dflt_ready,
  input logic                        sys_valid,
  input logic                        sys_ready,
  input logic [ADDR_W-1:0]           out_addr,
  input logic [DATA_W-1:0]           out_data,
  input logic                        out_wr,
  input logic                        ur_pulse
);
  localparam int NV = NUM_PORTS + 2;

  logic [NV-1:0]        vvec, rvec;
  logic                 stall;
  logic [NUM_PORTS-1:0] in_win;

  assign vvec  = {port_valid, dflt_valid, sys_valid};
  assign rvec  = {port_ready, dflt_ready, sys_ready};
  assign stall = (|vvec) && !(|(vvec & rvec));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_w
    logic [ADDR_W-1:0] lo_b, hi_b;
    localparam logic [NUM_PORTS-1:0] BELOW = NUM_PORTS'((64'd1 << g) - 64'd1);
    assign lo_b = win_lo[g*ADDR_W +: ADDR_W];
    assign hi_b = win_hi[g*ADDR_W +: ADDR_W];
    assign in_win[g] = (hi_b >= lo_b) && (out_addr >= lo_b) && (out_addr <= hi_b);

    assert_valid_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] |-> (hi_b >= lo_b));
    assert_claim_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] |-> (out_addr >= lo_b && out_addr <= hi_b));
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[g] |-> ((in_win & BELOW) == '0));
  end

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|vvec) || ur_pulse) |-> !in_ready);
  assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vvec, ur_pulse}));
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (vvec == $past(vvec)) && $stable(out_addr) && $stable(out_data) && $stable(out_wr));
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ur_pulse |=> (!ur_pulse && in_ready));
  assert_leftover_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_valid |-> (in_win == '0));
endmodule

bind bwin_router bwin_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .win_lo(win_lo), .win_hi(win_hi),
  .port_valid(port_valid), .port_ready(port_ready), .dflt_valid(dflt_valid),
  .dflt_ready(dflt_ready), .sys_valid(sys_valid), .sys_ready(sys_ready),
  .out_addr(out_addr), .out_data(out_data), .out_wr(out_wr), .ur_pulse(ur_pulse)
);

// File: tb/bwin_router_tb_top.sv
`timescale 1ns/1ps
module bwin_router_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          in_valid = 1'b0, in_wr = 1'b0, in_cls = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [N*AW-1:0] win_lo, win_hi;
  logic [AW-1:0] lo_a [N];
  logic [AW-1:0] hi_a [N];
  logic          dflt_en = 1'b1;
  logic [N-1:0]  port_valid;
  logic [N-1:0]  port_ready = '1;
  logic          dflt_valid, sys_valid, ur_pulse, out_wr;
  logic          dflt_ready = 1'b1, sys_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always_comb
    for (int i = 0; i < N; i++) begin
      win_lo[i*AW +: AW] = lo_a[i];
      win_hi[i*AW +: AW] = hi_a[i];
    end

  bwin_router #(.ADDR_W(AW), .DATA_W(DW), .NUM_PORTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_wr(in_wr), .in_cls(in_cls),
    .win_lo(win_lo), .win_hi(win_hi), .dflt_en(dflt_en),
    .port_valid(port_valid), .port_ready(port_ready),
    .dflt_valid(dflt_valid), .dflt_ready(dflt_ready),
    .sys_valid(sys_valid), .sys_ready(sys_ready),
    .out_addr(out_addr), .out_data(out_data), .out_wr(out_wr), .ur_pulse(ur_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R3";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: m_st 0 idle, 1 deciding, 2 presenting, 3 error pulse
  // targets: 0..N-1 bridge port, N default, N+1 system, N+2 unsupported
  int            m_st = 0, m_cnt = 0, m_tgt = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic          m_wr;

  function automatic int pick(logic [AW-1:0] a, logic c);
    if (c) return N + 1;
    for (int i = 0; i < N; i++)
      if (hi_a[i] >= lo_a[i] && a >= lo_a[i] && a <= hi_a[i]) return i;
    return dflt_en ? N : N + 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else case (m_st)
      0: if (in_valid) begin
        m_tgt = pick(in_addr, in_cls);
        m_addr = in_addr; m_data = in_data; m_wr = in_wr;
        m_cnt = (m_tgt < N || m_tgt == N + 1) ? 1 : 2;
        m_st = 1;
      end
      1: begin
        m_cnt--;
        if (m_cnt == 0) m_st = (m_tgt == N + 2) ? 3 : 2;
      end
      2: if ((m_tgt < N) ? port_ready[m_tgt] : (m_tgt == N) ? dflt_ready : sys_ready) m_st = 0;
      default: m_st = 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] epv;
      epv = (m_st == 2 && m_tgt < N) ? N'(1 << m_tgt) : '0;
      chk("R2", "in_ready", 64'(in_ready), 64'(m_st == 0));
      chk(cur_tag, "port_valid", 64'(port_valid), 64'(epv));
      chk(cur_tag, "dflt_valid", 64'(dflt_valid), 64'(m_st == 2 && m_tgt == N));
      chk(cur_tag, "sys_valid", 64'(sys_valid), 64'(m_st == 2 && m_tgt == N + 1));
      chk("R7", "ur_pulse", 64'(ur_pulse), 64'(m_st == 3));
      if (m_st == 2) begin
        chk("R9", "out_addr", 64'(out_addr), 64'(m_addr));
        chk("R9", "out_data", 64'(out_data), 64'(m_data));
        chk("R9", "out_wr", 64'(out_wr), 64'(m_wr));
      end
    end
  end

  task automatic issue(logic [AW-1:0] a, logic [DW-1:0] d, logic w, logic c, string tag);
    @(posedge clk); #2;
    cur_tag = tag;
    in_valid = 1'b1; in_addr = a; in_data = d; in_wr = w; in_cls = c;
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (m_st != 0);
  endtask

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, logic w, logic c, string tag);
    issue(a, d, w, c, tag);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=idle");
    finish_run();
  end

  initial begin
    lo_a[0] = 32'h1000; hi_a[0] = 32'h1FFF;
    lo_a[1] = 32'h4000; hi_a[1] = 32'h7FFF;
    lo_a[2] = 32'h6000; hi_a[2] = 32'h8FFF;
    lo_a[3] = 32'hA000; hi_a[3] = 32'h9000; // inverted: invalid
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "in_ready in reset", 64'(in_ready), 64'd1);
    chk("R1", "valids in reset", 64'({port_valid, dflt_valid, sys_valid, ur_pulse}), 64'd0);
    @(posedge clk); #2 rst_n = 1'b1;

    send(32'h1000, 32'hA1, 1'b1, 1'b0, "R3");   // lower bound inclusive
    send(32'h1FFF, 32'hA2, 1'b0, 1'b0, "R3");   // upper bound inclusive
    send(32'h8000, 32'hA3, 1'b1, 1'b0, "R3");   // port 2 only
    send(32'h6800, 32'hA4, 1'b1, 1'b0, "R5");   // overlap 1/2 -> port 1
    send(32'h6000, 32'hA5, 1'b0, 1'b0, "R5");   // overlap start
    send(32'hA000, 32'hA6, 1'b1, 1'b0, "R4");   // only the invalid window's bound
    send(32'h9500, 32'hA7, 1'b1, 1'b0, "R4");   // between inverted bounds
    send(32'h2000, 32'hA8, 1'b0, 1'b0, "R6");   // just above port 0
    send(32'h0000, 32'hA9, 1'b1, 1'b0, "R6");
    send(32'h1500, 32'hAA, 1'b1, 1'b1, "R8");   // in port 0 window but system class
    send(32'h2000, 32'hAB, 1'b0, 1'b1, "R8");

    dflt_en = 1'b0;
    send(32'h3000, 32'hAC, 1'b1, 1'b0, "R7");
    send(32'h1800, 32'hAD, 1'b1, 1'b0, "R3");   // claims still work
    dflt_en = 1'b1;

    // back-pressure on a bridge port, default and system outputs
    port_ready = '0;
    issue(32'h1234, 32'hBEEF, 1'b1, 1'b0, "R9");
    repeat (5) @(posedge clk);
    #2 port_ready = '1;
    wait_idle();
    dflt_ready = 1'b0;
    issue(32'h3333, 32'hCAFE, 1'b0, 1'b0, "R9");
    repeat (4) @(posedge clk);
    #2 dflt_ready = 1'b1;
    wait_idle();
    sys_ready = 1'b0;
    issue(32'h7000, 32'hF00D, 1'b1, 1'b1, "R9");
    repeat (3) @(posedge clk);
    #2 sys_ready = 1'b1;
    wait_idle();
    // wrong-port ready must not release a stall
    port_ready = 4'b1101;
    issue(32'h5000, 32'h5151, 1'b1, 1'b0, "R9");
    repeat (4) @(posedge clk);
    #2 port_ready = '1;
    wait_idle();

    for (int k = 0; k < 8; k++)
      send(32'h1000 + 32'(k) * 32'h1400, 32'(k), k[0], 1'b0, "R3");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule